// File: doc/BRIEF.md
# Register-Mapped Memory Stream Unit

The unit sits beside a core's register file and lets chosen architectural register numbers stand for memory streams. Two load streams and one store stream can be set up at once. Each takes a register number, a start address, a signed address step and an element count. Once a load stream is set up, reading its register returns the oldest element of that stream's queue instead of the register file value. Once the store stream is set up, writing its register appends the value to a store queue instead of the register file. Register numbers that are not bound to a live stream pass straight through.

Address generators walk each stream's address sequence with a post-incremented pointer. Load requests go out before the core asks for the data, as long as the queue has room. The store queue drains to memory in order. The memory port is a single request/grant port, and read responses carry the stream number. When an instruction would read an empty load queue, or write to a full store queue, the unit raises `stall` and the instruction takes effect in no part until the condition clears. Results therefore depend only on the instruction sequence, not on memory timing.

Top module: `mem_stream_unit`

## Requirements
- R1: A read or write of a register number not bound to a live stream returns `rd_*_rf` on `rd_*_data`, and a write asserts `wr_rf_en`.
- R2: A read of a live load stream's register returns the element at address base + k*stride, where k counts the reads already taken from that stream. Each accepted read takes exactly one element.
- R3: Two different load streams read on ports A and B in the same cycle each return their own next element.
- R4: When both ports read the same load stream in one cycle, both ports get the same element and only one element is taken.
- R5: A write to the live store stream's register pushes `wr_data` and keeps `wr_rf_en` low. Pushed values reach memory (`mem_we`=1) in order at base + k*stride.
- R6: `stall` is high while a read hits an empty load queue, or while a write hits a full store queue. During a stall no element is taken or pushed, and `wr_rf_en` stays low.
- R7: Load requests go out without any read, and per stream at most DEPTH elements are granted and not yet read.
- R8: A stream issues exactly `count` memory requests. After `count` elements are read or written, its register falls back to the register file.
- R9: `done` bit 0 and bit 1 belong to load streams 0 and 1, and bit 2 belongs to the store stream. A bit is 0 after reset and after its stream is set up again. It becomes 1 once every element is read, or once every element is written to memory.
- R10: `cfg_sel` selects the stream: 0 for load 0, 1 for load 1, 2 for store; 3 has no effect. `mem_id` gives the load stream of a read request. The store stream has priority on the memory port. An ungranted store request keeps its address and data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Set up the stream chosen by cfg_sel |
| cfg_sel | input | 2 | Stream select (0 load0, 1 load1, 2 store) |
| cfg_reg | input | RW | Register number bound to the stream |
| cfg_base | input | AW | First element address |
| cfg_stride | input | AW | Address step per element (two's complement) |
| cfg_count | input | CW | Number of elements |
| rd_a_en | input | 1 | Operand A read |
| rd_a_idx | input | RW | Operand A register number |
| rd_a_rf | input | DW | Register file value for operand A |
| rd_a_data | output | DW | Operand A result |
| rd_b_en | input | 1 | Operand B read |
| rd_b_idx | input | RW | Operand B register number |
| rd_b_rf | input | DW | Register file value for operand B |
| rd_b_data | output | DW | Operand B result |
| wr_en | input | 1 | Destination write |
| wr_idx | input | RW | Destination register number |
| wr_data | input | DW | Destination value |
| wr_rf_en | output | 1 | Write enable passed to the register file |
| stall | output | 1 | Hold the core this cycle |
| done | output | 3 | Per-stream completion flags |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a store |
| mem_id | output | 1 | Load stream of a read request |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Store data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rid | input | 1 | Load stream of the response |
| mem_rdata | input | DW | Read response data |

## Verification
A bad queue pointer or occupancy count shows at once as a wrong value on `rd_a_data` or `rd_b_data`, or as a stall that should not be there, at the very next read of that stream. An address generator that steps wrongly shows on the first request it issues, because the memory model checks every granted address against base + k*stride. A count that runs past or falls short of its limit shows as an extra or missing request, or as a register that does not return to the register file, or as a `done` flag that is set at the wrong time. All of these appear within one stream's length.

// File: rtl/mem_stream_unit.sv
module mem_stream_unit #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int RW    = 5,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_reg,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_stride,
  input  logic [CW-1:0] cfg_count,
  input  logic          rd_a_en,
  input  logic [RW-1:0] rd_a_idx,
  input  logic [DW-1:0] rd_a_rf,
  output logic [DW-1:0] rd_a_data,
  input  logic          rd_b_en,
  input  logic [RW-1:0] rd_b_idx,
  input  logic [DW-1:0] rd_b_rf,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          wr_rf_en,
  output logic          stall,
  output logic [2:0]    done,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_id,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic          mem_rid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0]   FULL  = (PW+1)'(DEPTH);
  localparam logic [PW+1:0] LIMIT = (PW+2)'(DEPTH);

  logic [1:0]         ld_cfg;
  logic [1:0][RW-1:0] ld_reg;
  logic [1:0][AW-1:0] ld_addr, ld_stride;
  logic [1:0][CW-1:0] ld_iss, ld_use;
  logic [1:0][PW:0]   ld_cnt, ld_fly;
  logic [1:0][PW-1:0] ld_rp, ld_wp;
  logic [DW-1:0]      ldq [2][DEPTH];

  logic          st_cfg;
  logic [RW-1:0] st_reg;
  logic [AW-1:0] st_addr, st_stride;
  logic [CW-1:0] st_left;
  logic [PW:0]   st_cnt;
  logic [PW-1:0] st_rp, st_wp;
  logic [DW-1:0] stq [DEPTH];

  logic [1:0] hit_a, hit_b, ld_empty, ld_want, ld_pop, ld_push, ld_fire;
  logic st_hit, st_go, st_push, st_fire;

  for (genvar s = 0; s < 2; s++) begin : g_ld
    wire live = ld_cfg[s] && (ld_use[s] != '0);
    assign hit_a[s]    = rd_a_en && live && (rd_a_idx == ld_reg[s]);
    assign hit_b[s]    = rd_b_en && live && (rd_b_idx == ld_reg[s]);
    assign ld_empty[s] = (ld_cnt[s] == '0);
    assign ld_want[s]  = (ld_iss[s] != '0) &&
                         ((PW+2)'(ld_cnt[s]) + (PW+2)'(ld_fly[s]) < LIMIT);
    assign ld_pop[s]   = (hit_a[s] || hit_b[s]) && !stall;
    assign ld_push[s]  = mem_rvalid && (mem_rid == 1'(s));
    assign done[s]     = ld_cfg[s] && (ld_use[s] == '0);
  end

  assign st_hit  = wr_en && st_cfg && (st_left != '0) && (wr_idx == st_reg);
  assign stall   = |((hit_a | hit_b) & ld_empty) || (st_hit && st_cnt == FULL);
  assign st_push = st_hit && !stall;
  assign wr_rf_en = wr_en && !st_hit && !stall;
  assign done[2] = st_cfg && (st_left == '0) && (st_cnt == '0);

  assign rd_a_data = hit_a[0] ? ldq[0][ld_rp[0]] : hit_a[1] ? ldq[1][ld_rp[1]] : rd_a_rf;
  assign rd_b_data = hit_b[0] ? ldq[0][ld_rp[0]] : hit_b[1] ? ldq[1][ld_rp[1]] : rd_b_rf;

  assign st_go      = (st_cnt != '0);
  assign mem_req    = st_go || (|ld_want);
  assign mem_we     = st_go;
  assign mem_id     = !st_go && !ld_want[0];
  assign mem_addr   = st_go ? st_addr : (mem_id ? ld_addr[1] : ld_addr[0]);
  assign mem_wdata  = stq[st_rp];
  assign st_fire    = st_go && mem_gnt;
  assign ld_fire[0] = mem_gnt && !st_go && ld_want[0];
  assign ld_fire[1] = mem_gnt && !st_go && !ld_want[0] && ld_want[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cfg <= '0; ld_reg <= '0; ld_addr <= '0; ld_stride <= '0;
      ld_iss <= '0; ld_use <= '0; ld_cnt <= '0; ld_fly <= '0;
      ld_rp <= '0; ld_wp <= '0;
      st_cfg <= 1'b0; st_reg <= '0; st_addr <= '0; st_stride <= '0;
      st_left <= '0; st_cnt <= '0; st_rp <= '0; st_wp <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (cfg_we && cfg_sel == 2'(s)) begin
          ld_cfg[s] <= 1'b1; ld_reg[s] <= cfg_reg;
          ld_addr[s] <= cfg_base; ld_stride[s] <= cfg_stride;
          ld_iss[s] <= cfg_count; ld_use[s] <= cfg_count;
          ld_cnt[s] <= '0; ld_rp[s] <= '0; ld_wp[s] <= '0;
        end else begin
          if (ld_fire[s]) begin
            ld_addr[s] <= ld_addr[s] + ld_stride[s];
            ld_iss[s]  <= ld_iss[s] - 1'b1;
          end
          if (ld_push[s]) ld_wp[s] <= ld_wp[s] + 1'b1;
          if (ld_pop[s]) begin
            ld_rp[s]  <= ld_rp[s] + 1'b1;
            ld_use[s] <= ld_use[s] - 1'b1;
          end
          ld_cnt[s] <= ld_cnt[s] + (PW+1)'(ld_push[s]) - (PW+1)'(ld_pop[s]);
        end
        ld_fly[s] <= ld_fly[s] + (PW+1)'(ld_fire[s]) - (PW+1)'(ld_push[s]);
      end
      if (cfg_we && cfg_sel == 2'd2) begin
        st_cfg <= 1'b1; st_reg <= cfg_reg; st_addr <= cfg_base;
        st_stride <= cfg_stride; st_left <= cfg_count;
        st_cnt <= '0; st_rp <= '0; st_wp <= '0;
      end else begin
        if (st_push) begin
          st_wp   <= st_wp + 1'b1;
          st_left <= st_left - 1'b1;
        end
        if (st_fire) begin
          st_rp   <= st_rp + 1'b1;
          st_addr <= st_addr + st_stride;
        end
        st_cnt <= st_cnt + (PW+1)'(st_push) - (PW+1)'(st_fire);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++)
      if (ld_push[s]) ldq[s][ld_wp[s]] <= mem_rdata;
    if (st_push) stq[st_wp] <= wr_data;
  end
endmodule

// File: rtl/mem_stream_unit_chk.sv
module mem_stream_unit_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stall,
  input logic               wr_rf_en,
  input logic [2:0]         done,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_id,
  input logic               mem_gnt,
  input logic [AW-1:0]      mem_addr,
  input logic [DW-1:0]      mem_wdata,
  input logic [1:0][PW:0]   ld_cnt,
  input logic [1:0][PW:0]   ld_fly,
  input logic [1:0][CW-1:0] ld_iss,
  input logic [PW:0]        st_cnt
);
  localparam logic [PW+1:0] LIMIT = (PW+2)'(DEPTH);

  a_r6_stall_blocks_rf: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !wr_rf_en);
  a_r7_ld0_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((PW+2)'(ld_cnt[0]) + (PW+2)'(ld_fly[0])) <= LIMIT);
  a_r7_ld1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((PW+2)'(ld_cnt[1]) + (PW+2)'(ld_fly[1])) <= LIMIT);
  a_r8_no_issue_past_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (ld_iss[mem_id] != '0));
  a_r5_store_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (st_cnt != '0));
  a_r10_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_gnt) |=>
      (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)));
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done[0] |-> !(mem_req && !mem_we && !mem_id));
endmodule

bind mem_stream_unit mem_stream_unit_chk #(
  .AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH), .PW(PW)
) u_chk (.*);

// File: tb/tb_mem_stream_unit.sv
module tb_mem_stream_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [4:0] cfg_reg = 0;
  logic [31:0] cfg_base = 0, cfg_stride = 0; logic [15:0] cfg_count = 0;
  logic rd_a_en = 0, rd_b_en = 0, wr_en = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_rf = 0, rd_b_rf = 0, wr_data = 0;
  logic [31:0] rd_a_data, rd_b_data, mem_addr, mem_wdata;
  logic wr_rf_en, stall, mem_req, mem_we, mem_id;
  logic [2:0] done;
  logic mem_gnt = 0, mem_rvalid = 0, mem_rid = 0;
  logic [31:0] mem_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_stream_unit dut (.*);

  int checks = 0, errors = 0;
  int ld_n[2], ld_pop[2], st_n = 0, st_pn = 0;
  logic [31:0] ld_base[2], ld_str[2], st_base = 0, st_str = 0;
  logic [31:0] st_exp[64];
  logic [31:0] rq_d[64]; logic rq_id[64]; int rq_h = 0, rq_t = 0;
  logic mem_allow = 0, pw_v = 0; logic [31:0] pw_a = 0, pw_d = 0;

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0], a[15:0] ^ 16'hC3A5};
  endfunction
  function automatic logic [31:0] ld_exp(input int s);
    return mdata(ld_base[s] + 32'(ld_pop[s]) * ld_str[s]);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rq_h != rq_t && $urandom % 2 == 0) begin
      mem_rvalid = 1; mem_rdata = rq_d[rq_h % 64]; mem_rid = rq_id[rq_h % 64]; rq_h++;
    end else mem_rvalid = 0;
    if (pw_v) chk(mem_req && mem_we && mem_addr == pw_a && mem_wdata == pw_d,
                  "R10 store hold", mem_addr, pw_a);
    mem_gnt = mem_allow && ($urandom % 4 != 0);
    pw_v = mem_req && mem_we && !mem_gnt; pw_a = mem_addr; pw_d = mem_wdata;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        chk(mem_addr == st_base + 32'(st_n) * st_str, "R5 store addr", mem_addr, st_base + 32'(st_n) * st_str);
        chk(mem_wdata == st_exp[st_n % 64], "R5 store data", mem_wdata, st_exp[st_n % 64]);
        st_n++;
      end else begin
        int s; s = int'(mem_id);
        chk(mem_addr == ld_base[s] + 32'(ld_n[s]) * ld_str[s], "R2 load addr", mem_addr, ld_base[s] + 32'(ld_n[s]) * ld_str[s]);
        ld_n[s]++;
        chk(ld_n[s] - ld_pop[s] <= DEPTH, "R7 prefetch bound", 32'(ld_n[s] - ld_pop[s]), DEPTH);
        rq_d[rq_t % 64] = mdata(mem_addr); rq_id[rq_t % 64] = mem_id; rq_t++;
      end
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [4:0] r, input logic [31:0] b, input logic [31:0] st, input logic [15:0] n);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_reg = r; cfg_base = b; cfg_stride = st; cfg_count = n;
    if (sel < 2) begin ld_base[sel[0]] = b; ld_str[sel[0]] = st; ld_n[sel[0]] = 0; ld_pop[sel[0]] = 0; end
    else if (sel == 2) begin st_base = b; st_str = st; st_n = 0; st_pn = 0; end
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic core_op(input logic ea, input logic [4:0] ia, input logic eb, input logic [4:0] ib,
                         input logic ew, input logic [4:0] iw, input logic [31:0] dw,
                         output logic [31:0] da, output logic [31:0] db, output logic rfw, output int ns);
    @(negedge clk);
    rd_a_en = ea; rd_a_idx = ia; rd_b_en = eb; rd_b_idx = ib; wr_en = ew; wr_idx = iw; wr_data = dw;
    ns = 0; #1;
    while (stall) begin ns++; @(negedge clk); #1; end
    da = rd_a_data; db = rd_b_data; rfw = wr_rf_en;
    @(posedge clk); #1 rd_a_en = 0; rd_b_en = 0; wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; $display("FAIL watchdog act=timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
  end

  initial begin
    logic [31:0] da, db, e0, e1; logic rfw; int ns;
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int s = 0; s < 2; s++) begin ld_n[s] = 0; ld_pop[s] = 0; ld_base[s] = 0; ld_str[s] = 0; end
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // reset state
    chk(!stall && !mem_req && done == 3'b000, "R9 reset", {stall, mem_req, 27'd0, done}, 0);
    // R1 pass-through
    rd_a_rf = 32'h1111_2222; rd_b_rf = 32'h3333_4444;
    core_op(1, 5'd3, 1, 5'd4, 1, 5'd3, 32'h9, da, db, rfw, ns);
    chk(da == 32'h1111_2222 && db == 32'h3333_4444, "R1 read pass", da, 32'h1111_2222);
    chk(rfw == 1, "R1 write pass", 32'(rfw), 1);
    // R10 select 3 has no effect
    cfg(2'd3, 5'd3, 32'h500, 32'd4, 16'd3);
    repeat (5) @(posedge clk);
    chk(!mem_req && done == 0, "R10 sel3 ignored", {31'd0, mem_req}, 0);
    // R6 stall on empty load
    cfg(2'd0, 5'd5, 32'h100, 32'd4, 16'd6);
    @(negedge clk); rd_a_en = 1; rd_a_idx = 5; wr_en = 1; wr_idx = 7; #1;
    chk(stall == 1, "R6 empty stall", 32'(stall), 1);
    chk(wr_rf_en == 0, "R6 rf write held", 32'(wr_rf_en), 0);
    @(posedge clk); #1 rd_a_en = 0; wr_en = 0;
    // R7 prefetch without reads
    mem_allow = 1;
    repeat (20) @(posedge clk);
    chk(ld_n[0] == DEPTH, "R7 prefetch depth", 32'(ld_n[0]), DEPTH);
    for (int k = 0; k < 6; k++) begin
      e0 = ld_exp(0);
      core_op(1, 5'd5, 0, 5'd0, 0, 5'd0, 0, da, db, rfw, ns);
      ld_pop[0]++;
      chk(da == e0, "R2 load value", da, e0);
    end
    chk(done[0] == 1, "R9 done load0", {29'd0, done}, 1);
    repeat (10) @(posedge clk);
    chk(ld_n[0] == 6, "R8 request count", 32'(ld_n[0]), 6);
    core_op(1, 5'd5, 0, 5'd0, 0, 5'd0, 0, da, db, rfw, ns);
    chk(da == 32'h1111_2222, "R8 revert to rf", da, 32'h1111_2222);
    // R3 two streams, random gaps
    cfg(2'd0, 5'd2, 32'h1000, 32'd8, 16'd10);
    chk(done[0] == 0, "R9 done cleared on reconfig", {29'd0, done}, 0);
    cfg(2'd1, 5'd9, 32'h2000, 32'hFFFF_FFF8, 16'd10);
    for (int k = 0; k < 10; k++) begin
      repeat ($urandom % 4) @(posedge clk);
      e0 = ld_exp(0); e1 = ld_exp(1);
      core_op(1, 5'd2, 1, 5'd9, 0, 5'd0, 0, da, db, rfw, ns);
      ld_pop[0]++; ld_pop[1]++;
      chk(da == e0, "R3 port A stream0", da, e0);
      chk(db == e1, "R3 port B stream1", db, e1);
    end
    chk(done[1:0] == 2'b11, "R9 both loads done", {29'd0, done}, 3);
    // R4 same stream on both ports
    cfg(2'd0, 5'd4, 32'h300, 32'd4, 16'd4);
    for (int k = 0; k < 2; k++) begin
      e0 = ld_exp(0);
      core_op(1, 5'd4, 1, 5'd4, 0, 5'd0, 0, da, db, rfw, ns);
      ld_pop[0]++;
      chk(da == e0 && db == e0, "R4 shared head", db, e0);
    end
    e0 = ld_exp(0);
    core_op(1, 5'd4, 0, 5'd0, 0, 5'd0, 0, da, db, rfw, ns);
    ld_pop[0]++;
    chk(da == e0, "R4 single pop", da, e0);
    chk(done[0] == 0, "R9 not done early", {29'd0, done}, 0);
    e0 = ld_exp(0);
    core_op(1, 5'd4, 0, 5'd0, 0, 5'd0, 0, da, db, rfw, ns);
    ld_pop[0]++;
    chk(da == e0 && done[0] == 1, "R4 last element", da, e0);
    // R5/R6 store stream
    mem_allow = 0;
    repeat (3) @(posedge clk);
    cfg(2'd2, 5'd12, 32'h4000, 32'd16, 16'd8);
    for (int k = 0; k < DEPTH; k++) begin
      st_exp[st_pn] = $urandom;
      core_op(0, 5'd0, 0, 5'd0, 1, 5'd12, st_exp[st_pn], da, db, rfw, ns);
      chk(ns == 0 && rfw == 0, "R5 push no rf", 32'(ns), 0);
      st_pn++;
    end
    st_exp[st_pn] = $urandom;
    @(negedge clk); wr_en = 1; wr_idx = 12; wr_data = st_exp[st_pn]; #1;
    chk(stall == 1 && wr_rf_en == 0, "R6 full stall", 32'(stall), 1);
    mem_allow = 1;
    while (stall) begin @(negedge clk); #1; end
    @(posedge clk); #1 wr_en = 0; st_pn++;
    for (int k = st_pn; k < 8; k++) begin
      st_exp[st_pn] = $urandom;
      core_op(0, 5'd0, 0, 5'd0, 1, 5'd12, st_exp[st_pn], da, db, rfw, ns);
      st_pn++;
    end
    repeat (30) @(posedge clk);
    chk(st_n == 8, "R8 store count", 32'(st_n), 8);
    chk(done == 3'b111, "R9 store done", {29'd0, done}, 7);
    core_op(0, 5'd0, 0, 5'd0, 1, 5'd12, 32'h5, da, db, rfw, ns);
    chk(rfw == 1, "R8 store reverts to rf", 32'(rfw), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule